// File: doc/BRIEF.md
# Segment Register Descriptor Cache

This block holds a small bank of segment registers for a processor core. Each register pairs a software-visible 16-bit selector with a hidden cache of three fields: a 24-bit base, a 16-bit limit and 8 bits of access rights. A load request names one register and carries a selector plus an already-fetched descriptor. What the load does with the hidden fields depends on the protection-enable input. When protection is on, all three hidden fields come from the descriptor. When protection is off, only the base changes, to sixteen times the selector, and the limit and access rights keep whatever values an earlier protected load left behind.

A read port returns only the selector of a register. A translation port takes a register index and a 16-bit offset. One cycle later it gives the linear address, or a limit fault if the offset exceeds the cached limit. Translation always uses the hidden cache, whichever mode is active. Turning the mode input on or off changes no stored field by itself.

Top module: `seg_desc_cache`

## Requirements
- R1: After reset every register has selector 0, base 0, limit 0xFFFF and access rights 0x93. Bit 7 of the access rights is the present bit, so 0x93 means a present, writable data segment.
- R2: With protMode high, a load whose ldDescAcc bit 7 is set writes ldSel, ldDescBase, ldDescLimit and ldDescAcc into the named register. ldDone pulses high in the cycle after the load.
- R3: With protMode low, a load writes ldSel and sets the base to ldSel shifted left by 4 and zero-extended to 24 bits. It never raises npFault, and ldDone pulses in the cycle after the load.
- R4: With protMode low, a load leaves the cached limit and access rights of the named register unchanged.
- R5: rdSel returns only the 16-bit selector of register rdIdx, combinationally, in either mode.
- R6: A change of protMode alone alters no selector, base, limit or access-rights field.
- R7: When xlValid is high, the cycle after gives linAddr = (base + xlOffset) mod 2^24 with addrValid high and xlAcc equal to the register's access rights. The cache state used is the state before any load in the same cycle.
- R8: When xlValid is high and xlOffset is greater than the cached limit, limitFault is high for exactly that one result cycle and addrValid is low. An offset equal to the limit is legal. When xlValid is low, the next cycle has addrValid and limitFault low.
- R9: If rdIdx equals ldIdx in a cycle with an accepted load, rdSel shows the new ldSel in that same cycle.
- R10: With protMode high, a load whose ldDescAcc bit 7 is clear is rejected. npFault pulses in the next cycle, ldDone stays low and the register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| protMode | input | 1 | Protection enable (1 = protected) |
| ldValid | input | 1 | Segment load request |
| ldIdx | input | 2 | Register index to load |
| ldSel | input | 16 | Selector to load |
| ldDescBase | input | 24 | Descriptor base |
| ldDescLimit | input | 16 | Descriptor limit |
| ldDescAcc | input | 8 | Descriptor access rights, bit 7 present |
| ldDone | output | 1 | Load accepted (one cycle after the request) |
| npFault | output | 1 | Not-present rejection (one cycle after the request) |
| rdIdx | input | 2 | Register index to read |
| rdSel | output | 16 | Selector of rdIdx |
| xlValid | input | 1 | Translation request |
| xlIdx | input | 2 | Register used for translation |
| xlOffset | input | 16 | Offset to translate |
| linAddr | output | 24 | Linear address result |
| addrValid | output | 1 | linAddr is valid |
| limitFault | output | 1 | Offset exceeded the limit |
| xlAcc | output | 8 | Access rights of the translated register |

## Verification
Most corruption of a hidden field stays invisible until a translation reads it. A wrong base shows up as a wrong linAddr one cycle after the next request on that register. A wrong limit shows up as a missing or spurious limitFault, and wrong access rights show up on xlAcc. The bench therefore translates often through every register, with offsets near the cached limit. A selector error shows at once on rdSel in the same cycle. A mode-dependent error becomes visible only after a protected load followed by a real-mode load on the same register, so the stimulus flips protMode between loads.

// File: rtl/segcache_pkg.sv
package segcache_pkg;
  parameter int SEL_W  = 16;
  parameter int ACC_W  = 8;
  parameter int BASE_W = 24;
  parameter int LIM_W  = 16;
  parameter int OFF_W  = 16;
  parameter int PRESENT_BIT = 7;
  parameter int RM_SHIFT = 4;
  parameter logic [ACC_W-1:0] RESET_ACC = 8'h93;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ACC_W-1:0]  acc;
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  lim;
  } segEntry_t;

  typedef struct packed {
    logic              wrEn;
    logic              wrHidden;
    logic [1:0]        wrIdx;
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  lim;
    logic [ACC_W-1:0]  acc;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import segcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              protMode,
  input  logic              ldValid,
  input  logic [1:0]        ldIdx,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [BASE_W-1:0] ldDescBase,
  input  logic [LIM_W-1:0]  ldDescLimit,
  input  logic [ACC_W-1:0]  ldDescAcc,
  output ctrlStrobes_t      strobes,
  output logic              ldDone,
  output logic              npFault
);
  logic present;
  logic accept;
  logic reject;
  logic [BASE_W-1:0] rmBase;

  assign present = ldDescAcc[PRESENT_BIT];
  assign accept  = ldValid && (!protMode || present);
  assign reject  = ldValid && protMode && !present;
  assign rmBase  = BASE_W'(ldSel) << RM_SHIFT;

  always_comb begin
    strobes.wrEn     = accept;
    strobes.wrHidden = protMode;
    strobes.wrIdx    = ldIdx;
    strobes.sel      = ldSel;
    strobes.base     = protMode ? ldDescBase : rmBase;
    strobes.lim      = ldDescLimit;
    strobes.acc      = ldDescAcc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldDone  <= 1'b0;
      npFault <= 1'b0;
    end else begin
      ldDone  <= accept;
      npFault <= reject;
    end
  end
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import segcache_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int IDX_W = $clog2(NUM_SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [SEL_W-1:0]  rdSel,
  input  logic              xlValid,
  input  logic [IDX_W-1:0]  xlIdx,
  input  logic [OFF_W-1:0]  xlOffset,
  output logic [BASE_W-1:0] linAddr,
  output logic              addrValid,
  output logic              limitFault,
  output logic [ACC_W-1:0]  xlAcc
);
  segEntry_t bank [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : gSeg
    logic hit;
    assign hit = strobes.wrEn && (strobes.wrIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[g].sel  <= '0;
        bank[g].base <= '0;
        bank[g].lim  <= '1;
        bank[g].acc  <= RESET_ACC;
      end else if (hit) begin
        bank[g].sel  <= strobes.sel;
        bank[g].base <= strobes.base;
        if (strobes.wrHidden) begin
          bank[g].lim <= strobes.lim;
          bank[g].acc <= strobes.acc;
        end
      end
    end
  end

  // Selector read with same-cycle bypass of an accepted load
  always_comb begin
    if (strobes.wrEn && (strobes.wrIdx == rdIdx))
      rdSel = strobes.sel;
    else
      rdSel = bank[rdIdx].sel;
  end

  // Address formation from the hidden cache
  segEntry_t xlEnt;
  logic [BASE_W-1:0] sumAddr;
  logic overLimit;
  assign xlEnt     = bank[xlIdx];
  assign sumAddr   = xlEnt.base + BASE_W'(xlOffset);
  assign overLimit = (LIM_W'(xlOffset) > xlEnt.lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linAddr    <= '0;
      addrValid  <= 1'b0;
      limitFault <= 1'b0;
      xlAcc      <= '0;
    end else begin
      linAddr    <= sumAddr;
      addrValid  <= xlValid && !overLimit;
      limitFault <= xlValid && overLimit;
      xlAcc      <= xlEnt.acc;
    end
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import segcache_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int IDX_W = $clog2(NUM_SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              protMode,
  input  logic              ldValid,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [BASE_W-1:0] ldDescBase,
  input  logic [LIM_W-1:0]  ldDescLimit,
  input  logic [ACC_W-1:0]  ldDescAcc,
  output logic              ldDone,
  output logic              npFault,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [SEL_W-1:0]  rdSel,
  input  logic              xlValid,
  input  logic [IDX_W-1:0]  xlIdx,
  input  logic [OFF_W-1:0]  xlOffset,
  output logic [BASE_W-1:0] linAddr,
  output logic              addrValid,
  output logic              limitFault,
  output logic [ACC_W-1:0]  xlAcc
);
  ctrlStrobes_t strobes;

  seg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .protMode(protMode),
    .ldValid(ldValid), .ldIdx(2'(ldIdx)), .ldSel(ldSel),
    .ldDescBase(ldDescBase), .ldDescLimit(ldDescLimit), .ldDescAcc(ldDescAcc),
    .strobes(strobes), .ldDone(ldDone), .npFault(npFault)
  );

  seg_datapath #(.NUM_SEGS(NUM_SEGS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .rdIdx(rdIdx), .rdSel(rdSel),
    .xlValid(xlValid), .xlIdx(xlIdx), .xlOffset(xlOffset),
    .linAddr(linAddr), .addrValid(addrValid),
    .limitFault(limitFault), .xlAcc(xlAcc)
  );
endmodule

// File: rtl/seg_desc_cache_chk.sv
module seg_desc_cache_chk
  import segcache_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              protMode,
  input logic              ldValid,
  input logic [IDX_W-1:0]  ldIdx,
  input logic [SEL_W-1:0]  ldSel,
  input logic [ACC_W-1:0]  ldDescAcc,
  input logic              ldDone,
  input logic              npFault,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [SEL_W-1:0]  rdSel,
  input logic              xlValid,
  input logic              addrValid,
  input logic              limitFault
);
  AST_DONE_AFTER_PM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && protMode && ldDescAcc[PRESENT_BIT]) |=> ldDone); // R2
  AST_RM_LOAD_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && !protMode) |=> (ldDone && !npFault)); // R3
  AST_SEL_HOLDS_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ldValid) && $stable(rdIdx) && !ldValid) |-> $stable(rdSel)); // R6
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(limitFault && addrValid)); // R8
  AST_RESULT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (limitFault || addrValid) |-> $past(xlValid)); // R8
  AST_BYPASS_RM: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && !protMode && ldIdx == rdIdx) |-> (rdSel == ldSel)); // R9
  AST_NP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && protMode && !ldDescAcc[PRESENT_BIT]) |=> (npFault && !ldDone)); // R10
endmodule

bind seg_desc_cache seg_desc_cache_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .protMode(protMode), .ldValid(ldValid),
  .ldIdx(ldIdx), .ldSel(ldSel), .ldDescAcc(ldDescAcc), .ldDone(ldDone),
  .npFault(npFault), .rdIdx(rdIdx), .rdSel(rdSel), .xlValid(xlValid),
  .addrValid(addrValid), .limitFault(limitFault)
);

// File: tb/seg_desc_cache_tb.sv
module seg_desc_cache_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic protMode = 0, ldValid = 0, xlValid = 0;
  logic [1:0] ldIdx = 0, rdIdx = 0, xlIdx = 0;
  logic [15:0] ldSel = 0, ldDescLimit = 0, xlOffset = 0;
  logic [23:0] ldDescBase = 0;
  logic [7:0] ldDescAcc = 0;
  logic ldDone, npFault, addrValid, limitFault;
  logic [15:0] rdSel;
  logic [23:0] linAddr;
  logic [7:0] xlAcc;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [15:0] mSel [4];
  logic [23:0] mBase [4];
  logic [15:0] mLim [4];
  logic [7:0]  mAcc [4];

  always #4 clk = ~clk;

  seg_desc_cache u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic accepts(logic pm, logic [7:0] acc);
    return !pm || acc[7];
  endfunction

  function automatic logic [23:0] expLin(logic [1:0] i, logic [15:0] off);
    return mBase[i] + {8'h0, off};
  endfunction

  // One cycle: drive at negedge, check rdSel, clock, check registered outputs
  task automatic step(logic pm, logic lv, logic [1:0] li, logic [15:0] ls,
                      logic [23:0] lb, logic [15:0] ll, logic [7:0] la,
                      logic [1:0] ri, logic xv, logic [1:0] xi, logic [15:0] xo);
    logic eAcc, eDone, eNp, eFault, eValid;
    logic [23:0] eLin;
    logic [7:0] eXAcc;
    protMode = pm; ldValid = lv; ldIdx = li; ldSel = ls; ldDescBase = lb;
    ldDescLimit = ll; ldDescAcc = la; rdIdx = ri; xlValid = xv; xlIdx = xi;
    xlOffset = xo;
    #1;
    eAcc = lv && accepts(pm, la);
    check((eAcc && li == ri) ? "R9 rdSel bypass" : "R5 rdSel",
          32'(rdSel), 32'((eAcc && li == ri) ? ls : mSel[ri]));
    eDone = eAcc;
    eNp = lv && !accepts(pm, la);
    eFault = xv && (xo > mLim[xi]);
    eValid = xv && !eFault;
    eLin = expLin(xi, xo);
    eXAcc = mAcc[xi];
    if (eAcc) begin
      mSel[li] = ls;
      if (pm) begin
        mBase[li] = lb; mLim[li] = ll; mAcc[li] = la;
      end else begin
        mBase[li] = {4'h0, ls, 4'h0};
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(pm ? "R2 ldDone" : "R3 ldDone", 32'(ldDone), 32'(eDone));
    check("R10 npFault", 32'(npFault), 32'(eNp));
    check("R8 limitFault", 32'(limitFault), 32'(eFault));
    check("R8 addrValid", 32'(addrValid), 32'(eValid));
    if (eValid) check("R7 linAddr", 32'(linAddr), 32'(eLin));
    if (xv) check("R7 xlAcc", 32'(xlAcc), 32'(eXAcc));
  endtask

  task automatic xl(logic pm, logic [1:0] i, logic [15:0] off);
    step(pm, 0, 0, 0, 0, 0, 0, i, 1, i, off);
  endtask

  initial begin
    void'($urandom(32'h5EC0DE));
    for (int i = 0; i < 4; i++) begin
      mSel[i] = 0; mBase[i] = 0; mLim[i] = 16'hFFFF; mAcc[i] = 8'h93;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state: selector 0, base 0, limit FFFF, acc 93
    for (int i = 0; i < 4; i++) xl(0, 2'(i), 16'hFFFF);
    // R2 protected load, then R7 wrap of base + offset
    step(1, 1, 1, 16'h0028, 24'hFFFFF0, 16'h00FF, 8'h92, 1, 0, 0, 0);
    xl(1, 1, 16'h0020);
    // R8 limit boundary: equal passes, one above faults
    xl(1, 1, 16'h00FF);
    xl(1, 1, 16'h0100);
    // R6 mode flip alone changes nothing; R4 real-mode load keeps limit
    xl(0, 1, 16'h0100);
    step(0, 1, 1, 16'h1234, 24'hABCDEF, 16'hFFFF, 8'h00, 1, 0, 0, 0);
    // R3 base becomes selector * 16; R4 limit 00FF and acc 92 retained
    xl(0, 1, 16'h00FF);
    xl(0, 1, 16'h0100);
    // R10 not-present rejection leaves register unchanged
    step(1, 1, 2, 16'h7777, 24'h123456, 16'h0010, 8'h12, 2, 1, 2, 16'h0020);
    xl(1, 2, 16'hFFFF);
    // R9 bypass with simultaneous translation of the same register
    step(1, 1, 3, 16'hBEEF, 24'h000100, 16'h0004, 8'h93, 3, 1, 3, 16'h0008);
    xl(1, 3, 16'h0008);
    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic pm, lv, xv;
      logic [1:0] li, xi;
      logic [15:0] xo;
      logic [7:0] la;
      pm = ($urandom % 8) < 4;
      lv = ($urandom % 3) == 0;
      li = 2'($urandom);
      la = 8'($urandom);
      if (($urandom % 5) != 0) la[7] = 1'b1;
      xv = ($urandom % 4) != 0;
      xi = 2'($urandom);
      case ($urandom % 4)
        0: xo = mLim[xi];
        1: xo = mLim[xi] + 16'd1;
        default: xo = 16'($urandom);
      endcase
      step(pm, lv, li, 16'($urandom), 24'($urandom), 16'($urandom % 3 == 0 ? 16'($urandom) : 16'($urandom % 1024)),
           la, 2'($urandom), xv, xi, xo);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule